// File: doc/BRIEF.md
# Lane-Configurable Bidirectional Shift Chain

This block holds a 96-stage shift register that feeds its whole contents, in parallel, to a downstream latch. The stages are shared out as 2, 3, 4 or 6 interleaved lanes. In n-lane operation, lane k (1-based) owns stages k, k+n, k+2n and so on, up to stage 96-n+k. Every lane moves one position along its own stages on each rising clock edge. A two-bit mode input picks the lane count. A direction input picks which way all lanes shift.

Each lane has two ports, an A side and a B side. When shifting toward higher stage numbers, the A side takes data in and the B side carries the lane's last stage out, so the next device in a chain can be fed directly. When shifting toward lower stage numbers, the roles swap. Each side has an input, an output and an output enable, so no tristate pads are needed. An active-low clear empties the chain at any time.

The operating modes are named TWO (2'b11), THREE (2'b10), FOUR (2'b01) and SIX (2'b00). There is no sequencing state beyond the stage register, which is either cleared (clear low) or shifting (clear high).

Top module: `lane_shift_chain`

## Requirements
- R1: `mode_sel` selects the lane count n: 2'b11 gives 2 lanes of 48 stages, 2'b10 gives 3 lanes of 32, 2'b01 gives 4 lanes of 24, and 2'b00 gives 6 lanes of 16. Bit i of every 6-bit port belongs to lane i+1.
- R2: With `dir_right` high, each rising edge with clear released does two things. It loads stage j (1 ≤ j ≤ n) from `a_in[j-1]`. It loads every other stage j from stage j-n. Stage j is bit j-1 of `stage_q`.
- R3: With `dir_right` low, each rising edge with clear released does two things. It loads stage 96-n+j (1 ≤ j ≤ n) from `b_in[j-1]`. It loads every other stage j from stage j+n.
- R4: With `dir_right` high, `b_out[j-1]` shows stage 96-n+j for each active lane j. It follows the register contents just after each edge.
- R5: With `dir_right` low, `a_out[j-1]` shows stage j for each active lane j.
- R6: For each active lane, the output enable is asserted on the output side only: `b_oe` when `dir_right` is high, `a_oe` when it is low. The enable on the input side is deasserted.
- R7: Port bits of lanes n+1 to 6 have no effect as inputs. Their outputs read 0 and their enables stay deasserted.
- R8: `clr_n` low clears all 96 stages at once, without waiting for a clock edge. The stages stay at zero for as long as `clr_n` is low, whatever the clock does.
- R9: A change of `dir_right` between edges takes effect at the next edge. The stage contents already in the chain are kept and move the other way from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Lane-count select |
| dir_right | input | 1 | 1: shift toward higher stages; 0: toward lower stages |
| a_in | input | 6 | A-side serial inputs, one per lane |
| a_out | output | 6 | A-side cascade outputs |
| a_oe | output | 6 | A-side output enables |
| b_in | input | 6 | B-side serial inputs, one per lane |
| b_out | output | 6 | B-side cascade outputs |
| b_oe | output | 6 | B-side output enables |
| stage_q | output | 96 | Parallel view of all stages, bit j-1 holds stage j |

## Verification
The assertions watch every cycle for these properties:
- the per-mode shift relation of the stage register in both directions;
- the cascade outputs showing what was one step short of the lane end on the previous cycle;
- enables on the output side only;
- silent unused lanes;
- an empty chain while clear is low.

Only the bench scenarios can show the rest:
- that the mode pins map to the right lane count;
- that serial data from the inputs lands in the right stages over a whole fill;
- that a mid-stream reversal keeps the contents;
- that clear empties the chain before any clock edge arrives.

// File: rtl/lane_chain_pkg.sv
package lane_chain_pkg;

    localparam int NUM_OPTS = 4;
    localparam int OPT_W    = 2;

    typedef enum logic [1:0] {
        LM_SIX   = 2'b00,
        LM_FOUR  = 2'b01,
        LM_THREE = 2'b10,
        LM_TWO   = 2'b11
    } lane_mode_e;

    // lane count for each option index; every value divides the chain length
    function automatic int opt_lanes(input int idx);
        case (idx)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/lane_mode_decode.sv
module lane_mode_decode
    import lane_chain_pkg::*;
#(
    parameter int MAX_LANES = 6
) (
    input  logic [1:0]           mode_sel,
    output logic [OPT_W-1:0]     opt_idx,
    output logic [MAX_LANES-1:0] lane_mask
);

    lane_mode_e mode;
    assign mode = lane_mode_e'(mode_sel);

    always_comb begin
        unique case (mode)
            LM_TWO:   opt_idx = OPT_W'(0);
            LM_THREE: opt_idx = OPT_W'(1);
            LM_FOUR:  opt_idx = OPT_W'(2);
            LM_SIX:   opt_idx = OPT_W'(3);
        endcase
    end

    always_comb begin
        for (int i = 0; i < MAX_LANES; i++) begin
            lane_mask[i] = (i < opt_lanes(int'(opt_idx)));
        end
    end

endmodule

// File: rtl/stage_array.sv
module stage_array
    import lane_chain_pkg::*;
#(
    parameter int TOTAL     = 96,
    parameter int MAX_LANES = 6
) (
    input  logic                 clk,
    input  logic                 clr_n,
    input  logic                 dir_right,
    input  logic [OPT_W-1:0]     opt_idx,
    input  logic [MAX_LANES-1:0] a_in,
    input  logic [MAX_LANES-1:0] b_in,
    output logic [TOTAL-1:0]     q
);

    logic [TOTAL-1:0] up_cand [NUM_OPTS];
    logic [TOTAL-1:0] dn_cand [NUM_OPTS];
    logic [TOTAL-1:0] nxt;

    // one candidate pair per lane option; the selected option is muxed in
    for (genvar m = 0; m < NUM_OPTS; m++) begin : g_opt
        localparam int N = opt_lanes(m);

        assign up_cand[m] = {q[TOTAL-1-N:0], a_in[N-1:0]};
        assign dn_cand[m] = {b_in[N-1:0], q[TOTAL-1:N]};

        AST_UP_SHIFT: assert property (@(posedge clk) disable iff (!clr_n)
            (opt_idx == OPT_W'(m) && dir_right) |=> q[TOTAL-1:N] == $past(q[TOTAL-1-N:0])); // R2

        AST_DN_SHIFT: assert property (@(posedge clk) disable iff (!clr_n)
            (opt_idx == OPT_W'(m) && !dir_right) |=> q[TOTAL-1-N:0] == $past(q[TOTAL-1:N])); // R3
    end

    assign nxt = dir_right ? up_cand[opt_idx] : dn_cand[opt_idx];

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/port_steer.sv
module port_steer
    import lane_chain_pkg::*;
#(
    parameter int TOTAL     = 96,
    parameter int MAX_LANES = 6
) (
    input  logic                 clk,
    input  logic                 clr_n,
    input  logic                 dir_right,
    input  logic [OPT_W-1:0]     opt_idx,
    input  logic [MAX_LANES-1:0] lane_mask,
    input  logic [TOTAL-1:0]     q,
    output logic [MAX_LANES-1:0] a_out,
    output logic [MAX_LANES-1:0] a_oe,
    output logic [MAX_LANES-1:0] b_out,
    output logic [MAX_LANES-1:0] b_oe
);

    logic [MAX_LANES-1:0] head_c [NUM_OPTS];
    logic [MAX_LANES-1:0] tail_c [NUM_OPTS];

    for (genvar m = 0; m < NUM_OPTS; m++) begin : g_opt
        localparam int N = opt_lanes(m);

        assign head_c[m] = (MAX_LANES)'(q[N-1:0]);
        assign tail_c[m] = (MAX_LANES)'(q[TOTAL-1 -: N]);

        AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!clr_n)
            (opt_idx == OPT_W'(m) && dir_right) |=>
            (!(opt_idx == OPT_W'(m) && dir_right) || b_out[N-1:0] == $past(q[TOTAL-1-N -: N]))); // R4

        AST_HEAD_FOLLOWS: assert property (@(posedge clk) disable iff (!clr_n)
            (opt_idx == OPT_W'(m) && !dir_right) |=>
            (dir_right || opt_idx != OPT_W'(m) || a_out[N-1:0] == $past(q[2*N-1:N]))); // R5
    end

    always_comb begin
        if (dir_right) begin
            b_out = tail_c[opt_idx];
            b_oe  = lane_mask;
            a_out = '0;
            a_oe  = '0;
        end else begin
            a_out = head_c[opt_idx];
            a_oe  = lane_mask;
            b_out = '0;
            b_oe  = '0;
        end
    end

    AST_OE_ONE_SIDE: assert property (@(posedge clk) disable iff (!clr_n)
        (a_oe & b_oe) == '0 && (dir_right ? a_oe == '0 : b_oe == '0)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!clr_n)
        (a_out & ~a_oe) == '0 && (b_out & ~b_oe) == '0); // R7

endmodule

// File: rtl/lane_shift_chain.sv
module lane_shift_chain
    import lane_chain_pkg::*;
#(
    parameter int TOTAL     = 96,
    parameter int MAX_LANES = 6
) (
    input  logic                 clk,
    input  logic                 clr_n,
    input  logic [1:0]           mode_sel,
    input  logic                 dir_right,
    input  logic [MAX_LANES-1:0] a_in,
    output logic [MAX_LANES-1:0] a_out,
    output logic [MAX_LANES-1:0] a_oe,
    input  logic [MAX_LANES-1:0] b_in,
    output logic [MAX_LANES-1:0] b_out,
    output logic [MAX_LANES-1:0] b_oe,
    output logic [TOTAL-1:0]     stage_q
);

    logic [OPT_W-1:0]     opt_idx;
    logic [MAX_LANES-1:0] lane_mask;

    lane_mode_decode #(.MAX_LANES(MAX_LANES)) u_decode (
        .mode_sel  (mode_sel),
        .opt_idx   (opt_idx),
        .lane_mask (lane_mask)
    );

    stage_array #(.TOTAL(TOTAL), .MAX_LANES(MAX_LANES)) u_stages (
        .clk       (clk),
        .clr_n     (clr_n),
        .dir_right (dir_right),
        .opt_idx   (opt_idx),
        .a_in      (a_in),
        .b_in      (b_in),
        .q         (stage_q)
    );

    port_steer #(.TOTAL(TOTAL), .MAX_LANES(MAX_LANES)) u_steer (
        .clk       (clk),
        .clr_n     (clr_n),
        .dir_right (dir_right),
        .opt_idx   (opt_idx),
        .lane_mask (lane_mask),
        .q         (stage_q),
        .a_out     (a_out),
        .a_oe      (a_oe),
        .b_out     (b_out),
        .b_oe      (b_oe)
    );

    always @(posedge clk) begin
        if (!clr_n) begin
            AST_CLEAR_EMPTY: assert (stage_q == '0); // R8
        end
    end

endmodule

// File: tb/tb_lane_shift_chain.sv
module tb_lane_shift_chain;

    logic        clk = 1'b0;
    logic        clr_n;
    logic [1:0]  mode_sel;
    logic        dir_right;
    logic [5:0]  a_in, b_in;
    logic [5:0]  a_out, a_oe, b_out, b_oe;
    logic [95:0] stage_q;

    int    n_chk = 0;
    int    n_bad = 0;
    string stage_tag = "R2";
    logic [95:0] mdl;

    always #2 clk = ~clk;

    lane_shift_chain dut (
        .clk(clk), .clr_n(clr_n), .mode_sel(mode_sel), .dir_right(dir_right),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .stage_q(stage_q)
    );

    function automatic int lanes_of(input logic [1:0] ms);
        case (ms)
            2'b11:   return 2;
            2'b10:   return 3;
            2'b01:   return 4;
            default: return 6;
        endcase
    endfunction

    // behavioural reference: stages indexed 1..96 held in mdl[j-1]
    always @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            mdl <= '0;
        end else begin
            automatic int n = lanes_of(mode_sel);
            automatic logic [95:0] t = mdl;
            if (dir_right) begin
                for (int j = 96; j > n; j--) t[j-1] = mdl[j-1-n];
                for (int k = 1; k <= n; k++) t[k-1] = a_in[k-1];
            end else begin
                for (int j = 1; j <= 96 - n; j++) t[j-1] = mdl[j-1+n];
                for (int k = 1; k <= n; k++) t[96-n+k-1] = b_in[k-1];
            end
            mdl <= t;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        automatic int n = lanes_of(mode_sel);
        automatic logic [5:0] ea = '0, eb = '0, eaoe = '0, eboe = '0, act_mask = '0;
        for (int k = 0; k < n; k++) begin
            act_mask[k] = 1'b1;
            if (dir_right) eb[k] = mdl[96-n+k];
            else           ea[k] = mdl[k];
        end
        if (dir_right) eboe = act_mask; else eaoe = act_mask;
        chk(stage_q === mdl, stage_tag, stage_q, mdl);
        if (dir_right) chk((b_out & act_mask) === eb, "R4", 96'(b_out), 96'(eb));
        else           chk((a_out & act_mask) === ea, "R5", 96'(a_out), 96'(ea));
        chk(a_oe === eaoe && b_oe === eboe, "R6", 96'({a_oe, b_oe}), 96'({eaoe, eboe}));
        chk(((a_out | b_out | a_oe | b_oe) & ~act_mask) == 6'd0, "R7",
            96'((a_out | b_out | a_oe | b_oe) & ~act_mask), 96'd0);
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        a_in = 6'($urandom);
        b_in = 6'($urandom);
    endtask

    task automatic clear_pulse();
        @(negedge clk);
        compare_all();
        clr_n = 1'b0;
        #1;
        chk(stage_q == '0, "R8", stage_q, '0);   // before any clock edge
        a_in = 6'($urandom);
        b_in = 6'($urandom);
        @(negedge clk);                          // one rising edge while held low
        chk(stage_q == '0, "R8", stage_q, '0);
        compare_all();
        clr_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL timeout (all requirements) actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        automatic logic [1:0] modes [4] = '{2'b11, 2'b10, 2'b01, 2'b00};
        clr_n = 1'b0; mode_sel = 2'b11; dir_right = 1'b1; a_in = '1; b_in = '1;
        repeat (2) @(negedge clk);
        chk(stage_q == '0, "R8", stage_q, '0);
        chk(b_oe == 6'b000011 && a_oe == '0, "R6", 96'({a_oe, b_oe}), 96'(6'b000011));
        clr_n = 1'b1;

        // full fill, every mode, both directions; unused lane bits driven randomly
        foreach (modes[i]) begin
            for (int d = 1; d >= 0; d--) begin
                mode_sel  = modes[i];
                dir_right = d[0];
                stage_tag = d[0] ? "R2" : "R3";
                clear_pulse();
                for (int c = 0; c < 56; c++) step();
                @(negedge clk);
                chk($countones(a_oe | b_oe) == lanes_of(modes[i]), "R1",
                    96'($countones(a_oe | b_oe)), 96'(lanes_of(modes[i])));
                chk(stage_q === mdl, "R1", stage_q, mdl);
            end
        end

        // mid-stream reversal, three lanes
        mode_sel = 2'b10; dir_right = 1'b1; stage_tag = "R9";
        clear_pulse();
        for (int c = 0; c < 20; c++) step();
        @(negedge clk);
        dir_right = 1'b0;
        for (int c = 0; c < 20; c++) step();
        @(negedge clk);
        dir_right = 1'b1;
        for (int c = 0; c < 10; c++) step();

        // clear pulse in the middle of a six-lane run
        mode_sel = 2'b00; dir_right = 1'b0; stage_tag = "R3";
        for (int c = 0; c < 12; c++) step();
        clear_pulse();
        for (int c = 0; c < 8; c++) step();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule